// File: doc/BRIEF.md
# Scanline-Paced PWM Audio Output

This block turns a stream of 6-bit sound samples into a single pulse-width-modulated audio line. One sample is fetched from memory per video scanline, during horizontal blanking when the display needs no data, which gives about one sample every 44 µs. That is a sample rate near 22 kHz and an audio bandwidth up to roughly 11 kHz. The block sees the fetch slot as the overlap of a DMA-active input and a terminal-count input. It answers with a registered, single-cycle load pulse and takes the memory data on that pulse.

The captured value sets the duty cycle of a 64-clock PWM frame. A free-running 6-bit counter restarts at every load. The output is high while the counter is below the held sample, so a value D gives D high clocks in every frame. The sample is replayed frame after frame until the next load. An analogue low-pass filter after the pin recovers the waveform.

A small state machine runs the slot handshake. Its states are `ST_IDLE` (waiting for a slot), `ST_STROBE` (load pulse high) and `ST_HOLD` (slot still present, load already done). Its transitions are:
- IDLE→STROBE when the slot is seen.
- STROBE→HOLD if the slot persists.
- STROBE→IDLE if the slot has gone.
- HOLD→IDLE when the slot ends.

Top module: `snd_pwm_top`

## Requirements
- R1: While reset is asserted (rst_n low at a clock edge), from the next clock the load pulse and PWM output are low and the held sample is zero.
- R2: When fetch_active_i and term_count_i are both high at a clock edge and the machine is idle, load_pulse_o is high for exactly the following clock cycle.
- R3: A slot held high for many cycles produces only one load pulse. A new pulse needs the slot to drop for at least one edge first.
- R4: With only one of fetch_active_i or term_count_i high, no load pulse is produced.
- R5: The held sample takes sample_data_i at the clock edge that ends the load pulse cycle. Data at any other time is ignored.
- R6: From the edge that captures sample D, the PWM counter restarts at 0. pwm_o is high for counter values 0..D-1 and low for D..63, so each 64-clock frame has D high cycles.
- R7: A held sample of 0 keeps pwm_o constantly low.
- R8: The held sample repeats in every subsequent 64-clock frame until the next load.
- R9: A held sample of 63 gives 63 high cycles and one low cycle per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz-class sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_active_i | input | 1 | Memory fetch in progress for the audio slot |
| term_count_i | input | 1 | Timing chain terminal count |
| sample_data_i | input | 6 | Sample bits from memory |
| load_pulse_o | output | 1 | Registered single-cycle load strobe |
| pwm_o | output | 1 | Pulse-width-modulated audio |

## Verification
The load pulse is due one clock after the edge at which both slot inputs are first seen high. The sample, and the restart of the counter, land on the edge one clock after that. pwm_o then follows with no further register, so frame position i of the new sample is visible in the i-th cycle after that edge. The bench drives inputs and samples outputs on falling edges. It checks the pulse at the first falling edge after the slot edge, and it checks every one of two frames of pwm_o cycle by cycle from the second falling edge. Slot lengths, data and single-input noise are drawn at random with a fixed seed, and the expected level of each cycle comes from the sample value alone.

// File: rtl/snd_pkg.sv
package snd_pkg;
    localparam int SAMPLE_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_HOLD   = 2'd2
    } load_state_e;
endpackage

// File: rtl/snd_load_fsm.sv
module snd_load_fsm
    import snd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slot_i,
    output logic load_o
);
    load_state_e state_q;
    load_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (slot_i) state_d = ST_STROBE;
            ST_STROBE: state_d = slot_i ? ST_HOLD : ST_IDLE;
            ST_HOLD:   if (!slot_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from the registered state
    always_comb begin
        load_o = 1'b0;
        unique case (state_q)
            ST_STROBE: load_o = 1'b1;
            ST_IDLE, ST_HOLD: load_o = 1'b0;
            default:   load_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/snd_sample_hold.sv
module snd_sample_hold #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] sample_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)      sample_o <= '0;
        else if (load_i) sample_o <= data_i;
    end
endmodule

// File: rtl/snd_pwm_gen.sv
module snd_pwm_gen #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] count_o,
    output logic         pwm_o
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) count_o <= '0;
        else                     count_o <= count_o + ONE;
    end

    assign pwm_o = (count_o < level_i);
endmodule

// File: rtl/snd_pwm_top.sv
module snd_pwm_top
    import snd_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fetch_active_i,
    input  logic         term_count_i,
    input  logic [W-1:0] sample_data_i,
    output logic         load_pulse_o,
    output logic         pwm_o
);
    logic         slot;
    logic [W-1:0] held_sample;
    logic [W-1:0] pwm_count;

    assign slot = fetch_active_i & term_count_i;

    snd_load_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_i (slot),
        .load_o (load_pulse_o)
    );

    snd_sample_hold #(.W(W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_pulse_o),
        .data_i   (sample_data_i),
        .sample_o (held_sample)
    );

    snd_pwm_gen #(.W(W)) u_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (load_pulse_o),
        .level_i   (held_sample),
        .count_o   (pwm_count),
        .pwm_o     (pwm_o)
    );
endmodule

// File: rtl/snd_pwm_checker.sv
module snd_pwm_checker #(
    parameter int W = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         fetch_active_i,
    input logic         term_count_i,
    input logic [W-1:0] sample_data_i,
    input logic         load_pulse_o,
    input logic         pwm_o,
    input logic [W-1:0] held_sample,
    input logic [W-1:0] pwm_count
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!load_pulse_o && !pwm_o && held_sample == '0));

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse_o |=> !load_pulse_o);

    p_no_slot_no_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_active_i && term_count_i) |=> !load_pulse_o);

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse_o |=> (held_sample == $past(sample_data_i)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse_o |=> $stable(held_sample));

    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse_o |=> (pwm_count == '0));

    p_zero_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (held_sample == '0) |-> !pwm_o);
endmodule

bind snd_pwm_top snd_pwm_checker #(.W(W)) i_snd_pwm_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_active_i (fetch_active_i),
    .term_count_i   (term_count_i),
    .sample_data_i  (sample_data_i),
    .load_pulse_o   (load_pulse_o),
    .pwm_o          (pwm_o),
    .held_sample    (held_sample),
    .pwm_count      (pwm_count)
);

// File: tb/test_snd_pwm_top.sv
module test_snd_pwm_top;
    localparam int W      = 6;
    localparam int PERIOD = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fetch_active_i = 1'b0;
    logic         term_count_i = 1'b0;
    logic [W-1:0] sample_data_i = '0;
    logic         load_pulse_o;
    logic         pwm_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    snd_pwm_top #(.W(W)) i_snd_pwm_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_active_i (fetch_active_i),
        .term_count_i   (term_count_i),
        .sample_data_i  (sample_data_i),
        .load_pulse_o   (load_pulse_o),
        .pwm_o          (pwm_o)
    );

    function automatic bit exp_pwm(input int level, input int pos);
        return pos < level;
    endfunction

    task automatic check(input bit act, input bit exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // one slot carrying value d, held for hold cycles after capture
    task automatic play(input int d, input int hold);
        @(negedge clk);
        fetch_active_i = 1'b1;
        term_count_i   = 1'b1;
        sample_data_i  = W'(d);
        @(negedge clk);
        check(load_pulse_o, 1'b1, "R2", "load pulse after slot");
        @(negedge clk);
        for (int i = 0; i < PERIOD; i++) begin
            check(load_pulse_o, 1'b0, "R3", "no second pulse in slot");
            check(pwm_o, exp_pwm(d, i),
                  (d == 0) ? "R7" : ((d == PERIOD - 1) ? "R9" : "R6"), "frame one");
            sample_data_i = W'($urandom);  // R5: ignored after capture
            if (i + 1 >= hold) begin
                fetch_active_i = 1'b0;
                term_count_i   = 1'b0;
            end
            @(negedge clk);
        end
        for (int j = 0; j < PERIOD; j++) begin
            check(load_pulse_o, 1'b0, "R4", "single input no pulse");
            check(pwm_o, exp_pwm(d, j), "R8", "frame two repeat");
            sample_data_i = W'($urandom);
            if ($urandom_range(1, 0) == 1) begin
                fetch_active_i = 1'($urandom);
                term_count_i   = 1'b0;
            end else begin
                fetch_active_i = 1'b0;
                term_count_i   = 1'($urandom);
            end
            @(negedge clk);
        end
        fetch_active_i = 1'b0;
        term_count_i   = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        fetch_active_i = 1'b1;
        term_count_i   = 1'b1;
        sample_data_i  = 6'd40;
        @(negedge clk);
        check(load_pulse_o, 1'b0, "R1", "load low in reset");
        check(pwm_o, 1'b0, "R1", "pwm low in reset");
        fetch_active_i = 1'b0;
        term_count_i   = 1'b0;
        rst_n = 1'b1;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            check(pwm_o, 1'b0, "R7", "zero sample after reset");
            check(load_pulse_o, 1'b0, "R4", "no slot no pulse");
        end
        play(0, 5);
        play(PERIOD - 1, 1);
        play(1, 70);
        play(32, 3);
        play(17, 1);
        for (int n = 0; n < 20; n++)
            play(int'($urandom_range(PERIOD - 1, 0)), int'($urandom_range(40, 1)));
        finished = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!finished && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule